// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment Groups

This block adds two 16-bit operands and a carry-in and returns a 16-bit sum and a carry-out. It is purely combinational. The word is cut into five slices whose widths grow toward the most significant end: 2, 2, 3, 4 and 5 bits. The bottom slice is a plain ripple adder fed by the external carry-in.

Every slice above the bottom one works speculatively. It forms its sum with a carry-in of zero in a small ripple adder. It then forms the carry-in-of-one result by adding one to that sum-and-carry word, using an increment circuit one bit wider than the slice. The increment replaces a second ripple adder. The carry arriving from the slice below steers a two-way selector that picks the sum bits and the slice carry. The slices are sized so that each one's speculative result is ready at about the time its selecting carry arrives.

The block has no clock and no handshake. It sits inside a datapath where registers on either side set the timing.

Top module: `sqcs_adder16`

## Requirements
- R1: For all inputs, the 17-bit value {cout_o, sum_o} equals a_i + b_i + cin_i.
- R2: Result bits 1:0 equal the low two bits of a_i[1:0] + b_i[1:0] + cin_i, and no operand bit above bit 1 affects them.
- R3: Slice boundaries lie at bit positions 2, 4, 7 and 11. A carry produced at any boundary reaches the slice above it, and the sum is correct there.
- R4: In each upper slice, the carry-one result equals the carry-zero result plus one, taken modulo 2^(w+1) for a slice of width w. This includes the case where an all-ones slice wraps to zero with a carry.
- R5: In each upper slice, the carry-zero result equals the slice operands added with no carry-in, with the slice carry-out as its top bit.
- R6: Each upper slice outputs its carry-one result when the carry from the slice below is 1, and its carry-zero result when that carry is 0. Both the sum bits and the slice carry follow this choice.
- R7: cout_o is the selected carry of the top slice. It is 1 exactly when a_i + b_i + cin_i is 65536 or more.
- R8: 0xFFFF + 0xFFFF with carry-in 1 gives sum 0xFFFF and carry 1. 0xFFFF + 0x0000 with carry-in 1 gives sum 0x0000 and carry 1. In the second case the carry passes through every slice.
- R9: With both operands and the carry-in at zero, the sum and the carry-out are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
All results are combinational and are due in the same cycle as the operands, with no register between input and output. The bench drives each operand set on the falling clock edge. It reads sum_o and cout_o a few nanoseconds later, well before the next rising edge, so every check sees settled values. The internal checker evaluates the slice-level relations whenever any input changes. Because those relations hold after every settle, they need no cycle offset.

// File: rtl/sqcs_pkg.sv
package sqcs_pkg;
  localparam int DATA_W = 16;
  localparam int NGRP   = 5;

  typedef int grp_arr_t [NGRP];

  // Slice widths, least significant slice first; they must sum to DATA_W.
  localparam grp_arr_t GRP_W = '{2, 2, 3, 4, 5};

  function automatic int grp_off(input int g);
    int acc;
    acc = 0;
    for (int k = 0; k < g; k++) acc += GRP_W[k];
    return acc;
  endfunction

  function automatic int grp_max();
    int m;
    m = 0;
    for (int k = 0; k < NGRP; k++) if (GRP_W[k] > m) m = GRP_W[k];
    return m;
  endfunction

  localparam int RES_W = grp_max() + 1;
endpackage

// File: rtl/sqcs_ripple.sv
module sqcs_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] cy;
  assign cy[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i]  = a_i[i] ^ b_i[i] ^ cy[i];
    assign cy[i+1]   = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = cy[W];
endmodule

// File: rtl/sqcs_incr.sv
module sqcs_incr #(
  parameter int W = 4
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] inc_o
);
  // low_ones[i] is set when every bit below i is one
  logic [W-1:0] low_ones;
  assign low_ones[0] = 1'b1;
  assign inc_o[0]    = ~val_i[0];

  for (genvar i = 1; i < W; i++) begin : g_bit
    assign low_ones[i] = low_ones[i-1] & val_i[i-1];
    assign inc_o[i]    = val_i[i] ^ low_ones[i];
  end
endmodule

// File: rtl/sqcs_group.sv
module sqcs_group #(
  parameter int W     = 4,
  parameter bit FIRST = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic [W:0]   res0_o,
  output logic [W:0]   res1_o
);
  if (FIRST) begin : g_plain
    logic [W-1:0] s;
    logic         c;
    sqcs_ripple #(.W(W)) u_rca (
      .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .sum_o(s), .cout_o(c)
    );
    assign res0_o = {c, s};
    assign res1_o = {c, s};
    assign sum_o  = s;
    assign cout_o = c;
  end else begin : g_spec
    logic [W-1:0] s0;
    logic         c0;
    sqcs_ripple #(.W(W)) u_rca (
      .a_i(a_i), .b_i(b_i), .cin_i(1'b0), .sum_o(s0), .cout_o(c0)
    );
    assign res0_o = {c0, s0};

    sqcs_incr #(.W(W + 1)) u_inc (
      .val_i(res0_o), .inc_o(res1_o)
    );

    assign {cout_o, sum_o} = cin_i ? res1_o : res0_o;
  end
endmodule

// File: rtl/sqcs_adder16.sv
module sqcs_adder16
  import sqcs_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o
);
  logic [NGRP:0]  cy;
  logic [RES_W-1:0] res0 [NGRP];
  logic [RES_W-1:0] res1 [NGRP];

  assign cy[0] = cin_i;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int OFF = grp_off(g);
    localparam int W   = GRP_W[g];
    logic [W:0] r0;
    logic [W:0] r1;

    sqcs_group #(.W(W), .FIRST(g == 0)) u_grp (
      .a_i   (a_i[OFF +: W]),
      .b_i   (b_i[OFF +: W]),
      .cin_i (cy[g]),
      .sum_o (sum_o[OFF +: W]),
      .cout_o(cy[g+1]),
      .res0_o(r0),
      .res1_o(r1)
    );

    assign res0[g] = RES_W'(r0);
    assign res1[g] = RES_W'(r1);
  end

  assign cout_o = cy[NGRP];
endmodule

// File: rtl/sqcs_adder16_chk.sv
module sqcs_adder16_chk
  import sqcs_pkg::*;
(
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              cin_i,
  input logic [DATA_W-1:0] sum_o,
  input logic              cout_o,
  input logic [NGRP:0]     cy,
  input logic [RES_W-1:0]  res0 [NGRP],
  input logic [RES_W-1:0]  res1 [NGRP]
);
  always_comb begin
    assert_total_R1: assert ({cout_o, sum_o} ==
                             ({1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i}))
      else $error("R1 sum mismatch");
    assert_low_slice_R2: assert (sum_o[1:0] ==
                                 2'(a_i[1:0] + b_i[1:0] + {1'b0, cin_i}))
      else $error("R2 low slice mismatch");
    assert_cout_top_R7: assert (cout_o == cy[NGRP])
      else $error("R7 carry-out not top slice carry");
  end

  for (genvar g = 1; g < NGRP; g++) begin : g_up
    localparam int OFF = grp_off(g);
    localparam int W   = GRP_W[g];
    logic [W:0] exp0;
    logic [W:0] r0;
    logic [W:0] r1;
    always_comb begin
      r0   = res0[g][W:0];
      r1   = res1[g][W:0];
      exp0 = {1'b0, a_i[OFF +: W]} + {1'b0, b_i[OFF +: W]};
      assert_spec_zero_R5: assert (r0 == exp0)
        else $error("R5 carry-zero result wrong in slice %0d", g);
      assert_spec_one_R4: assert (r1 == r0 + 1'b1)
        else $error("R4 carry-one result wrong in slice %0d", g);
      assert_select_R6: assert ({cy[g+1], sum_o[OFF +: W]} == (cy[g] ? r1 : r0))
        else $error("R6 selection wrong in slice %0d", g);
    end
  end
endmodule

bind sqcs_adder16 sqcs_adder16_chk u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .cin_i (cin_i),
  .sum_o (sum_o),
  .cout_o(cout_o),
  .cy    (cy),
  .res0  (res0),
  .res1  (res1)
);

// File: tb/sqcs_adder16_tb_top.sv
module sqcs_adder16_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic        cin = 1'b0;
  logic [15:0] sum;
  logic        cout;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  sqcs_adder16 dut_i (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  task automatic chk(input string req, input logic [16:0] got, input logic [16:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h cin=%b)", req, got, exp, a, b, cin);
    end
  endtask

  // Drive on falling edge; combinational result is read 5 ns later.
  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c);
    @(negedge clk);
    a = x; b = y; cin = c;
    #5;
  endtask

  task automatic add_chk(input string req, input logic [15:0] x, input logic [15:0] y,
                         input logic c);
    apply(x, y, c);
    chk(req, {cout, sum}, {1'b0, x} + {1'b0, y} + {16'd0, c});
  endtask

  task automatic t_reset_zero;
    @(negedge clk); #5;
    chk("R9", {cout, sum}, 17'd0);
    apply(16'h0000, 16'h0000, 1'b0);
    chk("R9", {cout, sum}, 17'd0);
  endtask

  task automatic t_low_slice;
    // R2: upper bits toggled must not disturb bits 1:0
    apply(16'hFFFC, 16'h0000, 1'b1);
    chk("R2", {15'd0, sum[1:0]}, 17'd1);
    apply(16'h0003, 16'hAAA8, 1'b1);
    chk("R2", {15'd0, sum[1:0]}, 17'd0);
    add_chk("R2", 16'h0002, 16'h0001, 1'b1);
  endtask

  task automatic t_boundaries;
    // R3: carry generated just below each boundary 2,4,7,11
    add_chk("R3", 16'h0003, 16'h0001, 1'b0);
    add_chk("R3", 16'h000F, 16'h0001, 1'b0);
    add_chk("R3", 16'h007F, 16'h0001, 1'b0);
    add_chk("R3", 16'h07FF, 16'h0001, 1'b0);
    add_chk("R3", 16'h0400, 16'h0400, 1'b0);
    add_chk("R3", 16'h0040, 16'h0040, 1'b1);
  endtask

  task automatic t_increment_wrap;
    // R4: all-ones slices fed a carry wrap to zero with carry out
    apply(16'hFFFC, 16'h0000, 1'b0);
    chk("R4", {cout, sum}, 17'h0FFFC);
    apply(16'hFFFC, 16'h0004, 1'b0);
    chk("R4", {cout, sum}, 17'h10000);
    add_chk("R4", 16'h0780, 16'h0000, 1'b0);
    add_chk("R4", 16'h07FC, 16'h0004, 1'b0);
  endtask

  task automatic t_select;
    // R5/R6: same upper operands, slice carry-in 0 then 1
    add_chk("R5", 16'h1230, 16'h4560, 1'b0);
    add_chk("R6", 16'h1233, 16'h4561, 1'b0);
    add_chk("R6", 16'h5A5B, 16'hA5A5, 1'b0);
    add_chk("R6", 16'h5A5A, 16'hA5A5, 1'b1);
  endtask

  task automatic t_carry_out;
    apply(16'h8000, 16'h7FFF, 1'b0);
    chk("R7", {16'd0, cout}, 17'd0);
    apply(16'h8000, 16'h7FFF, 1'b1);
    chk("R7", {16'd0, cout}, 17'd1);
    apply(16'h8000, 16'h8000, 1'b0);
    chk("R7", {16'd0, cout}, 17'd1);
  endtask

  task automatic t_all_ones;
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    chk("R8", {cout, sum}, 17'h1FFFF);
    apply(16'hFFFF, 16'h0000, 1'b1);
    chk("R8", {cout, sum}, 17'h10000);
  endtask

  task automatic t_sweep;
    // R1: exhaustive on low 6-bit fields and on a high field
    for (int i = 0; i < 64; i++)
      for (int j = 0; j < 64; j++)
        for (int c = 0; c < 2; c++)
          add_chk("R1", 16'(i), 16'(j), 1'(c));
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++)
        add_chk("R1", 16'(i << 11) | 16'h07FF, 16'(j << 11), 1'b1);
  endtask

  task automatic t_random;
    for (int k = 0; k < 2000; k++)
      add_chk("R1", 16'($urandom), 16'($urandom), 1'($urandom));
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_zero();
    t_low_slice();
    t_boundaries();
    t_increment_wrap();
    t_select();
    t_carry_out();
    t_all_ones();
    t_sweep();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule